// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel word into a single asynchronous line frame on a Tx wire that idles high. A frame opens with a low start bit. The data field follows, least significant bit first, with a length of 5 to 8 bits. An optional even or odd parity bit comes next, and the frame closes with 1, 1.5 or 2 high stop bits.

Timing comes from an external baud generator. It supplies a one-cycle oversample tick, and every bit lasts a fixed number of ticks. A word is handed over through a valid/ready handshake. The data length, parity mode and stop-bit count are sampled together with the word at the moment of hand-over. Software may therefore change the format between any two frames while the block runs, without disturbing a frame already in flight. A busy flag stays high while a frame is on the line.

Top module: `serial_frame_tx`

## Requirements
- R1: During reset and whenever no frame is in flight, `tx_o` is high and `busy_o` is low.
- R2: `ready_o` is high only while idle and only in a cycle where `tick_i` is high. A word is taken on a clock edge where `valid_i` and `ready_o` are both high, and from the next cycle `busy_o` is high.
- R3: The start bit drives `tx_o` low for exactly 16 ticks, counted from the acceptance edge.
- R4: The data field has 5 + `len_i` bits (`len_i` 0..3 gives 5..8 bits). It is sent least significant bit first, with each bit lasting 16 ticks.
- R5: `par_i` = 2'b01 adds an even parity bit, 2'b10 adds an odd parity bit, and 2'b00 or 2'b11 adds none. Even parity makes the count of ones over the sent data bits and the parity bit even. Odd parity makes that count odd. The parity bit lasts 16 ticks and follows the last data bit.
- R6: `stop_i` = 2'b00 gives a high stop period of 16 ticks, 2'b01 gives 24 ticks (1.5 bits), and 2'b10 or 2'b11 gives 32 ticks.
- R7: The data word, length, parity and stop settings are captured at acceptance. Later changes to `data_i`, `len_i`, `par_i` or `stop_i` do not alter the frame in flight.
- R8: `tx_o` changes only on clock edges where `tick_i` is high. If ticks pause, the line holds its level and the frame resumes where it stopped.
- R9: `busy_o` falls on the tick edge that ends the last stop tick, with `tx_o` high. The next word can be accepted on the very next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample tick from the baud generator, one cycle wide |
| data_i | input | 8 | Word to send |
| valid_i | input | 1 | Word on `data_i` is offered |
| ready_o | output | 1 | Block will take the word on this edge |
| len_i | input | 2 | Data length code: bit count is 5 + code |
| par_i | input | 2 | Parity code: 00/11 none, 01 even, 10 odd |
| stop_i | input | 2 | Stop code: 00 one bit, 01 one and a half bits, 10/11 two bits |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in flight |

## Verification
The assertions check on every cycle that the line is high whenever the block is not busy, and that ready appears only when idle and on a tick. They also check that an accepted word pulls the line low on the next cycle, that the line never moves without a tick, and that busy falls only on a tick with the line high. Only the bench's scenarios can show the frame contents: bit order, the parity value for each mode, the 16/24/32-tick stop lengths, and that format changes made mid-frame have no effect. The bench also shows the back-to-back start on the first tick after a frame and the correct resumption after a tick pause.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } sft_state_e;

  localparam logic [1:0] PAR_EVEN    = 2'b01;
  localparam logic [1:0] PAR_ODD     = 2'b10;
  localparam logic [1:0] STOP_ONE    = 2'b00;
  localparam logic [1:0] STOP_ONE_HF = 2'b01;
endpackage

// File: rtl/sft_parity.sv
module sft_parity #(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8,
  parameter int LW       = 2
) (
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [LW-1:0]       len_i,
  input  logic                odd_i,
  output logic                par_o
);
  localparam int NW = $clog2(MAX_BITS + 1);

  logic [NW-1:0]       nbits;
  logic [MAX_BITS-1:0] mask;

  assign nbits = NW'(MIN_BITS) + NW'(len_i);

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_mask
    assign mask[g] = (NW'(g) < nbits);
  end

  assign par_o = (^(data_i & mask)) ^ odd_i;
endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = en_i && tick_i && (cnt_q == len_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (last_o)        cnt_q <= '0;
    else if (tick_i)        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int OVS      = 16,
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [1:0]          len_i,
  input  logic [1:0]          par_i,
  input  logic [1:0]          stop_i,
  output logic                tx_o,
  output logic                busy_o
);
  import sft_pkg::*;

  localparam int LW = 2;
  localparam int IW = $clog2(MAX_BITS);
  localparam int CW = $clog2(2 * OVS) + 1;

  sft_state_e          state_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic [IW-1:0]       idx_q;
  logic [LW-1:0]       len_q;
  logic [1:0]          par_q, stop_q;
  logic                pbit_q, pbit_d;
  logic [CW-1:0]       phase_len, stop_len;
  logic                last, accept, par_on;
  logic [IW-1:0]       last_idx;

  assign ready_o  = (state_q == ST_IDLE) && tick_i;
  assign accept   = valid_i && ready_o;
  assign busy_o   = (state_q != ST_IDLE);
  assign par_on   = (par_q == PAR_EVEN) || (par_q == PAR_ODD);
  assign last_idx = IW'(MIN_BITS - 1) + IW'(len_q);

  always_comb begin
    case (stop_q)
      STOP_ONE:    stop_len = CW'(OVS);
      STOP_ONE_HF: stop_len = CW'(OVS + OVS / 2);
      default:     stop_len = CW'(2 * OVS);
    endcase
  end

  assign phase_len = (state_q == ST_STOP) ? stop_len : CW'(OVS);

  sft_parity #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .LW(LW)) u_par (
    .data_i (data_i),
    .len_i  (len_i),
    .odd_i  (par_i == PAR_ODD),
    .par_o  (pbit_d)
  );

  sft_bit_timer #(.CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (busy_o),
    .len_i  (phase_len),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      par_q   <= '0;
      stop_q  <= '0;
      pbit_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_START;
          shreg_q <= data_i;
          len_q   <= len_i;
          par_q   <= par_i;
          stop_q  <= stop_i;
          pbit_q  <= pbit_d;
        end
        ST_START: if (last) begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: if (last) begin
          shreg_q <= shreg_q >> 1;
          idx_q   <= idx_q + IW'(1);
          if (idx_q == last_idx) state_q <= par_on ? ST_PARITY : ST_STOP;
        end
        ST_PARITY: if (last) state_q <= ST_STOP;
        ST_STOP:   if (last) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START:  tx_o = 1'b0;
      ST_DATA:   tx_o = shreg_q[0];
      ST_PARITY: tx_o = pbit_q;
      default:   tx_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic valid_i,
  input logic ready_o,
  input logic tx_o,
  input logic busy_o
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  a_r2_ready_idle_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!busy_o && tick_i));

  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (busy_o && !tx_o));

  a_r8_move_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tx_o));

  a_r9_end_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(tick_i) && tx_o));
endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .tx_o    (tx_o),
  .busy_o  (busy_o)
);

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tick_en = 1'b1;
  logic [1:0] div = 2'd0;
  logic [7:0] data = 8'h00;
  logic       valid = 1'b0;
  logic [1:0] len = 2'd3, par = 2'd0, stop = 2'd0;
  logic       ready, tx, busy;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!tick_en) tick <= 1'b0;
    else begin
      div  <= div + 2'd1;
      tick <= (div == 2'd3);
    end
  end

  serial_frame_tx u_dut (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .data_i (data),
    .valid_i (valid), .ready_o (ready), .len_i (len), .par_i (par),
    .stop_i (stop), .tx_o (tx), .busy_o (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // drive one frame and rebuild it from the line
  task automatic run_frame(input logic [7:0] d, input logic [1:0] l, input logic [1:0] p,
                           input logic [1:0] s, input bit perturb, input bit pause,
                           input bit chk_gap, input string req);
    int  sv[12];
    int  sl[12];
    int  ns = 0;
    int  nb = 5 + int'(l);
    int  ones = 0;
    bit  rdy_bad = 0;
    sv[ns] = 0; sl[ns] = 16; ns++;
    for (int i = 0; i < nb; i++) begin
      sv[ns] = int'(d[i]); sl[ns] = 16; ns++;
      ones += int'(d[i]);
    end
    if (p == 2'b01 || p == 2'b10) begin
      sv[ns] = (ones % 2) ^ ((p == 2'b10) ? 1 : 0); sl[ns] = 16; ns++;
    end
    sv[ns] = 1; sl[ns] = (s == 2'b00) ? 16 : (s == 2'b01) ? 24 : 32; ns++;

    data = d; len = l; par = p; stop = s; valid = 1'b1;
    while (!ready) begin
      if (chk_gap && tick) check(1'b0, "R9 back-to-back ready on first tick", 0, 1);
      @(negedge clk);
    end
    if (chk_gap) check(1'b1, "R9 back-to-back accept", 1, 1);
    @(negedge clk);
    valid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    if (perturb) begin
      data = ~d; len = l + 2'd1; par = p ^ 2'b11; stop = s ^ 2'b01;
    end
    for (int k = 0; k < ns; k++) begin
      int rem = sl[k];
      bit seg_ok = 1;
      int seen = int'(tx);
      while (rem > 0) begin
        if (tx !== sv[k][0]) begin seg_ok = 0; seen = int'(tx); end
        if (ready) rdy_bad = 1;
        if (pause && k == 2 && rem == 8 && !tick) begin
          bit hold_ok = 1;
          tick_en = 1'b0;
          for (int w = 0; w < 40; w++) begin
            @(negedge clk);
            if (tx !== sv[k][0] || tick) hold_ok = 0;
          end
          check(hold_ok, "R8 line held while ticks pause", int'(tx), sv[k]);
          tick_en = 1'b1;
        end
        if (tick) rem--;
        @(negedge clk);
      end
      check(seg_ok, $sformatf("%s seg%0d", req, k), seen, sv[k]);
    end
    check(busy == 1'b0 && tx == 1'b1, "R9 busy low and line high after stop",
          int'({busy, tx}), 1);
    check(!rdy_bad, "R2 ready low during frame", int'(rdy_bad), 0);
  endtask

  task automatic t_reset();
    check(tx == 1'b1, "R1 line high in reset", int'(tx), 1);
    check(busy == 1'b0, "R1 busy low in reset", int'(busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(tx == 1'b1 && busy == 1'b0, "R1 idle line high", int'({busy, tx}), 1);
  endtask

  task automatic t_lengths();
    run_frame(8'hA5, 2'd3, 2'b00, 2'b00, 0, 0, 0, "R3 R4 8-bit frame");
    run_frame(8'h13, 2'd0, 2'b00, 2'b00, 0, 0, 0, "R4 5-bit frame");
    run_frame(8'h6C, 2'd1, 2'b00, 2'b00, 0, 0, 0, "R4 6-bit frame");
    run_frame(8'h4B, 2'd2, 2'b00, 2'b00, 0, 0, 0, "R4 7-bit frame");
  endtask

  task automatic t_parity();
    run_frame(8'hB7, 2'd3, 2'b01, 2'b00, 0, 0, 0, "R5 even parity");
    run_frame(8'hB7, 2'd3, 2'b10, 2'b00, 0, 0, 0, "R5 odd parity");
    run_frame(8'hF0, 2'd0, 2'b01, 2'b00, 0, 0, 0, "R5 even parity masked 5-bit");
    run_frame(8'h00, 2'd2, 2'b10, 2'b00, 0, 0, 0, "R5 odd parity zero word");
    run_frame(8'h55, 2'd3, 2'b11, 2'b00, 0, 0, 0, "R5 code 11 no parity");
  endtask

  task automatic t_stops();
    run_frame(8'h81, 2'd3, 2'b00, 2'b01, 0, 0, 0, "R6 one and a half stop");
    run_frame(8'h81, 2'd3, 2'b01, 2'b10, 0, 0, 0, "R6 two stop");
    run_frame(8'h3E, 2'd1, 2'b10, 2'b11, 0, 0, 0, "R6 code 11 two stop");
  endtask

  task automatic t_capture();
    run_frame(8'h9D, 2'd2, 2'b01, 2'b00, 1, 0, 0, "R7 settings captured at accept");
    run_frame(8'h2A, 2'd3, 2'b10, 2'b01, 1, 0, 0, "R7 settings captured 1.5 stop");
  endtask

  task automatic t_pause();
    run_frame(8'hC3, 2'd3, 2'b01, 2'b00, 0, 1, 0, "R8 frame after tick pause");
  endtask

  task automatic t_back_to_back();
    run_frame(8'h5A, 2'd3, 2'b00, 2'b00, 0, 0, 0, "R9 first of pair");
    run_frame(8'hA6, 2'd3, 2'b01, 2'b01, 0, 0, 1, "R9 second of pair");
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lengths();
    t_parity();
    t_stops();
    t_capture();
    t_pause();
    t_back_to_back();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule